// File: doc/BRIEF.md
# APB Requester with Wait-State Support

This block is a bus master for the APB protocol. It takes simple commands from local logic (an address, a read/write flag and write data) on a valid/ready handshake and runs each one as a single APB transfer: a setup cycle, then an access cycle that repeats for as long as the slave holds PREADY low. When the slave completes the transfer, the block returns the read data and the slave's error flag on a one-cycle response strobe.

One slave select is driven and there is no address decoding. Only one transfer is in flight at a time. A command offered in the completing cycle of a transfer is taken at once, so transfers can follow each other with no idle cycle between them. Between transfers, the address, direction and write-data lines stay at their last values instead of returning to zero, so the bus does not toggle while idle.

The controller has three states. `ST_IDLE` is the state with no transfer in progress. `ST_SETUP` drives select high and enable low. `ST_ACCESS` drives both high. The transitions are:

- `ST_IDLE` to `ST_SETUP` when a command is accepted.
- `ST_SETUP` to `ST_ACCESS` always.
- `ST_ACCESS` to `ST_ACCESS` while PREADY is low.
- `ST_ACCESS` to `ST_IDLE` when PREADY is high and no command is waiting.
- `ST_ACCESS` to `ST_SETUP` when PREADY is high and a command is accepted in that same cycle.

Top module: `apb_req_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `psel`, `penable` and `rsp_valid` are low and `cmd_ready` is high.
- R2: In the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both high at a rising edge), the block is in setup: `psel`=1 and `penable`=0. In that cycle `paddr`, `pwrite` and `pwdata` equal the accepted `cmd_addr`, `cmd_write` and `cmd_wdata`.
- R3: The cycle after a setup cycle is always an access cycle: `psel`=1 and `penable`=1.
- R4: While an access cycle sees `pready`=0, the next cycle keeps `psel`, `penable`, `paddr`, `pwrite` and `pwdata` unchanged. This holds for any number of wait cycles.
- R5: A transfer completes on the rising edge where `psel`, `penable` and `pready` are all 1. In the next cycle `rsp_valid` is high for exactly one cycle. `rsp_rdata` then carries the `prdata` sampled at that edge for a read (`pwrite`=0), and all zeros for a write (`pwrite`=1). Each accepted command gives exactly one response.
- R6: `rsp_err` equals the `pslverr` value sampled at the completing edge. `pslverr` has no effect in any other cycle.
- R7: After a completion with no new command accepted, `psel` and `penable` are low in the next cycle. `paddr`, `pwrite` and `pwdata` keep their last values for as long as no command is accepted.
- R8: `cmd_ready` is high in idle cycles and in an access cycle with `pready`=1, and low otherwise. A command offered while `cmd_ready` is low is not taken.
- R9: A command accepted in the completing cycle of a transfer starts its setup cycle in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block takes the command at this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err | output | 1 | Slave error flag from the completing edge |
| psel | output | 1 | APB slave select |
| penable | output | 1 | APB enable (access phase) |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pready | input | 1 | Slave ready / completion |
| prdata | input | DATA_W | Slave read data |
| pslverr | input | 1 | Slave error |

## Verification
The bench uses a slave model with a programmable number of wait cycles (0, 2, 3 and 5). With this it checks that every request line stays frozen across long waits. A design that re-latched the command, or dropped enable early, would show a changed address or a second setup cycle.

Commands are queued so that one is waiting when the previous transfer completes. This tests that the next setup follows with no gap; a design that could only accept commands in idle would insert an extra cycle there.

`pslverr` is held high outside the access phase and raised at the completing edge for one error address. A design that sampled it at the wrong time would flag responses that should be clean, or miss the real error. Long idle stretches between bursts check that the address and direction stay parked rather than being cleared.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apbm_state_e;
endpackage

// File: rtl/apbm_seq.sv
module apbm_seq
    import apbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic pready,
    output logic cmd_ready,
    output logic accept,
    output logic done,
    output logic psel,
    output logic penable
);
    timeunit 1ns;
    timeprecision 1ps;

    apbm_state_e state_q;
    apbm_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (pready) state_d = cmd_valid ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        psel      = 1'b0;
        penable   = 1'b0;
        cmd_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
            end
            ST_SETUP: begin
                psel = 1'b1;
            end
            ST_ACCESS: begin
                psel      = 1'b1;
                penable   = 1'b1;
                cmd_ready = pready;
                done      = pready;
            end
            default: begin
                psel = 1'b0;
            end
        endcase
        accept = cmd_valid && cmd_ready;
    end

    // R3: setup is always followed by access
    a_r3_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // R4: waiting access stays in access
    a_r4_wait_stays_access: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> (psel && penable));

    // R8: no command taken during setup or a waiting access
    a_r8_ready_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !(penable && pready)) |-> !cmd_ready);

    // R9: acceptance always leads into setup
    a_r9_accept_to_setup: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (psel && !penable));
endmodule

// File: rtl/apbm_hold.sv
module apbm_hold #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata
);
    timeunit 1ns;
    timeprecision 1ps;

    // Request lines load only on acceptance and are otherwise parked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr  <= '0;
            pwrite <= 1'b0;
            pwdata <= '0;
        end else if (accept) begin
            paddr  <= cmd_addr;
            pwrite <= cmd_write;
            pwdata <= cmd_wdata;
        end
    end

    // R2: the command seen at the accepting edge appears on the bus
    a_r2_cmd_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (paddr == $past(cmd_addr) && pwrite == $past(cmd_write)
                    && pwdata == $past(cmd_wdata)));
endmodule

// File: rtl/apbm_resp.sv
module apbm_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= done;
            if (done) begin
                rsp_rdata <= pwrite ? '0 : prdata;
                rsp_err   <= pslverr;
            end
        end
    end

    // R5: a completion gives exactly one response strobe in the next cycle
    a_r5_rsp_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rsp_valid);
    a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/apb_req_master.sv
module apb_req_master #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              psel,
    output logic              penable,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic              pready,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr
);
    timeunit 1ns;
    timeprecision 1ps;

    logic accept;
    logic done;

    apbm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .pready    (pready),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .done      (done),
        .psel      (psel),
        .penable   (penable)
    );

    apbm_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pwdata    (pwdata)
    );

    apbm_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .pwrite    (pwrite),
        .prdata    (prdata),
        .pslverr   (pslverr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    // R4: request lines frozen through wait cycles
    a_r4_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=>
        ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    // R7: bus released after completion unless a new command was taken
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && !(cmd_valid && cmd_ready)) |=> (!psel && !penable));

    // R7: address and direction stay parked while idle
    a_r7_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!psel && !(cmd_valid && cmd_ready)) |=> ($stable(paddr) && $stable(pwrite)));
endmodule

// File: tb/sim_apb_req_master.sv
module sim_apb_req_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int MEM_N = 16;
    localparam logic [AW-1:0] ERR_ADDR = 8'd13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic          psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic          pready;
    logic [DW-1:0] prdata;
    logic          pslverr;

    apb_req_master #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    // ---------------- slave model with programmable waits ----------------
    int unsigned   wait_cfg = 0;
    int unsigned   wcnt;
    logic          junk_err = 1'b0;
    logic [DW-1:0] smem [MEM_N];
    logic          in_access;

    assign in_access = psel && penable;
    assign pready    = in_access && (wcnt == wait_cfg);
    assign prdata    = smem[paddr[3:0]];
    assign pslverr   = in_access ? (paddr == ERR_ADDR) : junk_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= 0;
            for (int k = 0; k < MEM_N; k++) smem[k] <= '0;
        end else begin
            if (in_access && !pready) wcnt <= wcnt + 1;
            else                      wcnt <= 0;
            if (in_access && pready && pwrite) smem[paddr[3:0]] <= pwdata;
        end
    end

    // ---------------- counters and check helper ----------------
    int checks = 0;
    int errors = 0;
    int b2b_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [DW-1:0] model [MEM_N];
    logic [DW-1:0] q_data [$];
    logic          q_err  [$];

    initial for (int k = 0; k < MEM_N; k++) model[k] = '0;

    // driver: pushes expectation, offers command until accepted
    task automatic send(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit taken;
        q_data.push_back(wr ? '0 : model[a[3:0]]);
        q_err.push_back(a == ERR_ADDR);
        if (wr) model[a[3:0]] = d;
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_wdata = d;
        taken = 1'b0;
        while (!taken) begin
            @(negedge clk);
            taken = cmd_ready;
            @(posedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        cmd_addr  = ~a;
        cmd_write = ~wr;
        cmd_wdata = ~d;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((q_data.size() != 0 || psel) && guard < 200) begin
            @(posedge clk);
            #1;
            guard++;
        end
    endtask

    // monitor: responses and protocol rules, sampled at the falling edge
    logic          p_psel = 1'b0, p_pen = 1'b0, p_rdy = 1'b0, p_acc = 1'b0, p_wr = 1'b0;
    logic [AW-1:0] p_addr = '0, a_addr = '0;
    logic [DW-1:0] p_wd = '0, a_wd = '0;
    logic          a_wr = 1'b0;
    logic          mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R5", "unexpected response", rsp_rdata, '0);
                end else begin
                    chk(rsp_rdata == q_data[0], "R5", "response data", rsp_rdata, q_data[0]);
                    chk(rsp_err == q_err[0], "R6", "response error", {31'd0, rsp_err}, {31'd0, q_err[0]});
                    void'(q_data.pop_front());
                    void'(q_err.pop_front());
                end
            end
            // R8: ready only in idle or completing access
            chk(cmd_ready == (!psel || (penable && pready)), "R8", "cmd_ready",
                {31'd0, cmd_ready}, {31'd0, (!psel || (penable && pready))});
            if (p_acc) begin
                chk(psel && !penable, "R2", "setup after accept", {30'd0, psel, penable}, 32'd2);
                chk(paddr == a_addr && pwrite == a_wr && pwdata == a_wd, "R2", "setup addr",
                    {24'd0, paddr}, {24'd0, a_addr});
                if (p_pen) begin
                    b2b_seen++;
                    chk(psel && !penable, "R9", "back-to-back setup", {30'd0, psel, penable}, 32'd2);
                end
            end
            if (p_psel && !p_pen)
                chk(psel && penable, "R3", "access after setup", {30'd0, psel, penable}, 32'd3);
            if (p_psel && p_pen && !p_rdy)
                chk(psel && penable && paddr == p_addr && pwrite == p_wr && pwdata == p_wd,
                    "R4", "frozen in wait", {24'd0, paddr}, {24'd0, p_addr});
            if (p_psel && p_pen && p_rdy && !p_acc)
                chk(!psel && !penable, "R7", "released after done", {30'd0, psel, penable}, 32'd0);
            if (!p_acc && (!p_psel || (p_pen && p_rdy)))
                chk(paddr == p_addr && pwrite == p_wr && pwdata == p_wd, "R7", "parked lines",
                    {24'd0, paddr}, {24'd0, p_addr});
        end
        p_psel = psel; p_pen = penable; p_rdy = pready;
        p_acc  = cmd_valid && cmd_ready;
        p_addr = paddr; p_wr = pwrite; p_wd = pwdata;
        if (cmd_valid && cmd_ready) begin
            a_addr = cmd_addr; a_wr = cmd_write; a_wd = cmd_wdata;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        junk_err = 1'b1;
        repeat (2) @(negedge clk);
        // R1 during reset
        chk(!psel && !penable && !rsp_valid && cmd_ready, "R1", "reset outputs",
            {28'd0, psel, penable, rsp_valid, cmd_ready}, 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!psel && !penable && !rsp_valid && cmd_ready, "R1", "after reset",
            {28'd0, psel, penable, rsp_valid, cmd_ready}, 32'd1);
        @(posedge clk); #1;
        mon_on = 1'b1;

        // zero-wait writes then reads, back to back
        wait_cfg = 0;
        send(1'b1, 8'd1, 32'hA5A5_0001);
        send(1'b1, 8'd2, 32'h1234_5678);
        send(1'b1, 8'd3, 32'hDEAD_BEEF);
        send(1'b0, 8'd1, '0);
        send(1'b0, 8'd2, '0);
        send(1'b0, 8'd3, '0);
        drain();
        repeat (5) @(posedge clk);
        #1;

        // three wait cycles, mixed directions, junk error while idle
        wait_cfg = 3;
        send(1'b1, 8'd7, 32'h0BAD_F00D);
        send(1'b0, 8'd7, '0);
        send(1'b1, 8'd7, 32'h7777_0000);
        send(1'b0, 8'd2, '0);
        send(1'b0, 8'd7, '0);
        drain();
        repeat (8) @(posedge clk);
        #1;

        // error address with two waits
        wait_cfg = 2;
        send(1'b1, ERR_ADDR, 32'hEEEE_0013);
        send(1'b0, ERR_ADDR, '0);
        send(1'b0, 8'd1, '0);
        drain();
        junk_err = 1'b0;
        repeat (4) @(posedge clk);
        #1;

        // long waits with idle gaps between commands
        wait_cfg = 5;
        for (int n = 0; n < 4; n++) begin
            send(1'b1, 8'(4 + n), 32'hC0DE_0000 + n);
            repeat (3) @(posedge clk);
            #1;
        end
        for (int n = 0; n < 4; n++) send(1'b0, 8'(4 + n), '0);
        drain();
        repeat (4) @(posedge clk);
        #1;

        chk(q_data.size() == 0, "R5", "all responses returned", q_data.size(), 0);
        chk(b2b_seen > 0, "R9", "back-to-back observed", b2b_seen, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule